// File: doc/BRIEF.md
# PTP Transmit Slot Controller

The controller holds eight transmit buffers for timing frames and sends them one at a time onto a byte stream towards the MAC. The host fills a buffer with a length word followed by the frame bytes, then asks for it to go out by writing that buffer's request bit in the control register. Every requested buffer stays marked as waiting until its last byte has left. The controller always serves the lowest-numbered waiting buffer first. Host software relies on this order, because it picks the buffer just above the highest waiting bit.

When a frame's first byte is accepted on the stream, the controller takes a copy of the time input. After the last byte it writes that time into the tail of the buffer. It then clears the waiting bit, records the buffer index as the most recently sent, and raises an interrupt. A read of the control register takes the interrupt down.

Top module: `ptp_tx_slot_ctrl`

## Requirements
- R1: After reset the waiting mask is 0, the last-sent index is 0, `irq_o` is low and `tx_valid_o` is low.
- R2: The host port uses byte addresses and whole 32-bit words. Buffer i occupies bytes i*0x100 to i*0x100+0xFF, eight buffers in all. Buffer words read back what was last written. The control register sits at byte address 0x800.
- R3: Writing the control register with bit i (i in 0..7) set marks buffer i as waiting. Bits written as 0 change nothing. Control bits 15:8 read back the waiting mask, and bits 7:0 read as 0.
- R4: Among the waiting buffers, the lowest index is started first. A lower buffer requested while a higher one is sending goes out next, ahead of any higher waiting buffer.
- R5: A frame's length is word 0 of its buffer. A value of 0 is sent as 1 byte, and a value above 240 is sent as 240 bytes. Byte j of the frame is buffer byte 8+j, taken from the buffer word in little-endian lane order. `tx_last_o` marks the final byte.
- R6: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` does not change.
- R7: The seconds and nanoseconds inputs are captured on the clock edge that accepts the frame's first byte. They are written to buffer byte offsets 248 (seconds) and 252 (nanoseconds).
- R8: On completion, in the same clock edge, the buffer's waiting bit clears and control bits 18:16 take the buffer index. The timestamp is already in the buffer by then. The waiting bit stays set for the whole time its buffer is in progress.
- R9: Completion raises `irq_o` on the next edge. A control-register read with `host_re_i` clears it. If a completion and a read fall in the same cycle, the interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe; used to clear the interrupt |
| host_addr_i | input | ADDR_W | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data for the current address (combinational) |
| time_sec_i | input | 32 | Current time, seconds |
| time_ns_i | input | 32 | Current time, nanoseconds |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| irq_o | output | 1 | Transmit-done interrupt |

## Verification
The stall-stability and waiting-hold properties assume the host does not write a buffer while that buffer is waiting or being sent. Under that assumption the stream data comes only from stable buffer contents. The directed tests load every buffer completely before setting its request bit. They request more buffers only while some other buffer is active. During a send, the only host accesses are control-register reads and writes. The backpressure test drives `tx_ready_i` from an alternating pattern and never from the design's outputs. This keeps the stall checks free of races.

// File: rtl/ptp_tx_pkg.sv
package ptp_tx_pkg;
  localparam int N_SLOTS       = 8;
  localparam int IDX_W         = $clog2(N_SLOTS);
  localparam int SLOT_BYTES    = 256;
  localparam int SLOT_WORDS    = SLOT_BYTES / 4;
  localparam int SLOT_AW       = $clog2(SLOT_WORDS);
  localparam int MEM_WORDS     = N_SLOTS * SLOT_WORDS;
  localparam int MEM_AW        = $clog2(MEM_WORDS);
  localparam int DATA_BYTE_OFS = 8;
  localparam int TS_BYTE_OFS   = 248;
  localparam int DATA_WORD     = DATA_BYTE_OFS / 4;
  localparam int TS_SEC_WORD   = TS_BYTE_OFS / 4;
  localparam int TS_NS_WORD    = TS_SEC_WORD + 1;
  localparam int MAX_LEN       = TS_BYTE_OFS - DATA_BYTE_OFS;
  localparam int LEN_W         = $clog2(MAX_LEN + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SEND,
    ST_TS_SEC,
    ST_TS_NS
  } send_st_e;
endpackage

// File: rtl/ptp_tx_slot_ram.sv
module ptp_tx_slot_ram
  import ptp_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              h_we_i,
  input  logic [MEM_AW-1:0] h_addr_i,
  input  logic [31:0]       h_wdata_i,
  output logic [31:0]       h_rdata_o,
  input  logic              e_we_i,
  input  logic [MEM_AW-1:0] e_addr_i,
  input  logic [31:0]       e_wdata_i,
  output logic [31:0]       e_rdata_o
);
  logic [31:0] mem_q [MEM_WORDS];

  // engine write placed last: it wins a same-word collision
  always_ff @(posedge clk_i) begin
    if (h_we_i) mem_q[h_addr_i] <= h_wdata_i;
    if (e_we_i) mem_q[e_addr_i] <= e_wdata_i;
  end

  assign h_rdata_o = mem_q[h_addr_i];
  assign e_rdata_o = mem_q[e_addr_i];
endmodule

// File: rtl/ptp_tx_pending.sv
module ptp_tx_pending
  import ptp_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] set_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [N_SLOTS-1:0] waiting_o,
  output logic               any_o,
  output logic [IDX_W-1:0]   low_idx_o
);
  logic [N_SLOTS-1:0] wait_q, clr_mask;

  assign clr_mask = clr_i ? (N_SLOTS'(1) << clr_idx_i) : '0;

  // a request in the completing cycle re-queues the slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= '0;
    else         wait_q <= (wait_q & ~clr_mask) | set_i;
  end

  always_comb begin
    low_idx_o = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--)
      if (wait_q[i]) low_idx_o = IDX_W'(i);
  end

  assign waiting_o = wait_q;
  assign any_o     = |wait_q;

  AST_SET_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((waiting_o & $past(set_i)) == $past(set_i))); // R3
endmodule

// File: rtl/ptp_tx_sender.sv
module ptp_tx_sender
  import ptp_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               any_i,
  input  logic [IDX_W-1:0]   low_idx_i,
  input  logic [N_SLOTS-1:0] waiting_i,
  output logic [MEM_AW-1:0]  mem_addr_o,
  input  logic [31:0]        mem_rdata_i,
  output logic               mem_we_o,
  output logic [31:0]        mem_wdata_o,
  input  logic [31:0]        time_sec_i,
  input  logic [31:0]        time_ns_i,
  output logic [7:0]         tx_data_o,
  output logic               tx_valid_o,
  output logic               tx_last_o,
  input  logic               tx_ready_i,
  output logic               done_o,
  output logic [IDX_W-1:0]   done_idx_o
);
  send_st_e          st_q;
  logic [IDX_W-1:0]  cur_q;
  logic [LEN_W-1:0]  len_q, cnt_q, len_clamp;
  logic [31:0]       ts_sec_q, ts_ns_q;
  logic [SLOT_AW-1:0] word_ofs;

  always_comb begin
    if (mem_rdata_i == '0)                      len_clamp = LEN_W'(1);
    else if (mem_rdata_i > 32'(MAX_LEN))        len_clamp = LEN_W'(MAX_LEN);
    else                                        len_clamp = mem_rdata_i[LEN_W-1:0];
  end

  always_comb begin
    unique case (st_q)
      ST_SEND:   word_ofs = SLOT_AW'(DATA_WORD) + SLOT_AW'(cnt_q >> 2);
      ST_TS_SEC: word_ofs = SLOT_AW'(TS_SEC_WORD);
      ST_TS_NS:  word_ofs = SLOT_AW'(TS_NS_WORD);
      default:   word_ofs = '0;
    endcase
  end

  assign mem_addr_o  = {cur_q, word_ofs};
  assign mem_we_o    = (st_q == ST_TS_SEC) || (st_q == ST_TS_NS);
  assign mem_wdata_o = (st_q == ST_TS_SEC) ? ts_sec_q : ts_ns_q;
  assign tx_valid_o  = (st_q == ST_SEND);
  assign tx_data_o   = mem_rdata_i[8*cnt_q[1:0] +: 8];
  assign tx_last_o   = tx_valid_o && (cnt_q == len_q - LEN_W'(1));
  assign done_o      = (st_q == ST_TS_NS);
  assign done_idx_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      ts_sec_q <= '0;
      ts_ns_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (any_i) begin
          cur_q <= low_idx_i;
          st_q  <= ST_LOAD;
        end
        ST_LOAD: begin
          len_q <= len_clamp;
          cnt_q <= '0;
          st_q  <= ST_SEND;
        end
        ST_SEND: if (tx_ready_i) begin
          if (cnt_q == '0) begin
            ts_sec_q <= time_sec_i;
            ts_ns_q  <= time_ns_i;
          end
          if (tx_last_o) st_q <= ST_TS_SEC;
          else           cnt_q <= cnt_q + LEN_W'(1);
        end
        ST_TS_SEC: st_q <= ST_TS_NS;
        ST_TS_NS:  st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  AST_LOWEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD) |-> (($past(waiting_i) & ((N_SLOTS'(1) << cur_q) - N_SLOTS'(1))) == '0)); // R4
  AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> waiting_i[cur_q]); // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R6
  AST_TS_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_we_o) && $past(tx_valid_o, 2)); // R7
endmodule

// File: rtl/ptp_tx_slot_ctrl.sv
module ptp_tx_slot_ctrl
  import ptp_tx_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(12'h800)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  input  logic [31:0]       time_sec_i,
  input  logic [31:0]       time_ns_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  localparam int BUF_BYTES = MEM_WORDS * 4;

  logic               is_ctrl, is_buf, ctrl_rd;
  logic [N_SLOTS-1:0] set_req, waiting;
  logic               any_wait, done;
  logic [IDX_W-1:0]   low_idx, done_idx, last_idx_q;
  logic [MEM_AW-1:0]  e_addr;
  logic               e_we;
  logic [31:0]        e_wdata, e_rdata, h_rdata;
  logic               irq_q;

  assign is_ctrl = (host_addr_i == CTRL_ADDR);
  assign is_buf  = (host_addr_i < ADDR_W'(BUF_BYTES)) && (host_addr_i[1:0] == 2'b00);
  assign ctrl_rd = host_re_i && is_ctrl;
  assign set_req = (host_we_i && is_ctrl) ? host_wdata_i[N_SLOTS-1:0] : '0;

  ptp_tx_slot_ram u_ram (
    .clk_i    (clk_i),
    .h_we_i   (host_we_i && is_buf),
    .h_addr_i (host_addr_i[MEM_AW+1:2]),
    .h_wdata_i(host_wdata_i),
    .h_rdata_o(h_rdata),
    .e_we_i   (e_we),
    .e_addr_i (e_addr),
    .e_wdata_i(e_wdata),
    .e_rdata_o(e_rdata)
  );

  ptp_tx_pending u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_req),
    .clr_i    (done),
    .clr_idx_i(done_idx),
    .waiting_o(waiting),
    .any_o    (any_wait),
    .low_idx_o(low_idx)
  );

  ptp_tx_sender u_send (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_i      (any_wait),
    .low_idx_i  (low_idx),
    .waiting_i  (waiting),
    .mem_addr_o (e_addr),
    .mem_rdata_i(e_rdata),
    .mem_we_o   (e_we),
    .mem_wdata_o(e_wdata),
    .time_sec_i (time_sec_i),
    .time_ns_i  (time_ns_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_last_o  (tx_last_o),
    .tx_ready_i (tx_ready_i),
    .done_o     (done),
    .done_idx_o (done_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_idx_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (done) last_idx_q <= done_idx;
      if (done)         irq_q <= 1'b1;
      else if (ctrl_rd) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    if (is_ctrl)     host_rdata_o = {13'b0, last_idx_q, waiting, 8'b0};
    else if (is_buf) host_rdata_o = h_rdata;
    else             host_rdata_o = '0;
  end

  AST_LAST_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (last_idx_q == $past(done_idx))); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !waiting[$past(done_idx)] || $past(set_req[done_idx])); // R8
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> irq_o); // R9
  AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd && !done) |=> !irq_o); // R9
endmodule

// File: tb/ptp_tx_slot_ctrl_test.sv
module ptp_tx_slot_ctrl_test;
  localparam logic [11:0] CTRL = 12'h800;

  logic        clk = 0, rst_n = 0;
  logic        host_we = 0, host_re = 0;
  logic [11:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [31:0] tsec = 0, tns = 0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_ready = 0, irq;

  int checks = 0, bad = 0;
  int cyc = 0, rdy_mode = 0;
  logic [7:0] rx_b [2048];
  int rx_cnt = 0, frm_cnt = 0;
  int frm_start [32], frm_len [32];
  logic [31:0] frm_sec [32], frm_ns [32];
  bit in_frame = 0, stall_prev = 0;
  logic [7:0] data_prev = 0;

  always #10 clk = ~clk;

  ptp_tx_slot_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(host_we), .host_re_i(host_re), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .time_sec_i(tsec), .time_ns_i(tns),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream monitor, time source and ready pattern
  always @(negedge clk) begin
    cyc++;
    tsec = 32'(cyc);
    tns  = 32'(cyc * 13 + 5);
    case (rdy_mode)
      0: tx_ready = 0;
      1: tx_ready = 1;
      default: tx_ready = cyc[0];
    endcase
    if (stall_prev) chk(tx_valid && tx_data == data_prev, "R6 stall hold", {23'b0, tx_valid, tx_data}, {24'h1, data_prev});
    stall_prev = tx_valid && !tx_ready;
    data_prev  = tx_data;
    if (tx_valid && tx_ready) begin
      if (!in_frame) begin
        frm_start[frm_cnt] = rx_cnt;
        frm_sec[frm_cnt] = tsec;
        frm_ns[frm_cnt] = tns;
        in_frame = 1;
      end
      rx_b[rx_cnt] = tx_data;
      rx_cnt++;
      if (tx_last) begin
        frm_len[frm_cnt] = rx_cnt - frm_start[frm_cnt];
        frm_cnt++;
        in_frame = 0;
      end
    end
  end

  function automatic logic [7:0] pat(input int s, input int j);
    return 8'((s * 37 + j) & 255);
  endfunction

  task automatic hw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk); host_we = 0;
  endtask

  task automatic hr(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; host_re = 1; #1 d = host_rdata;
    @(negedge clk); host_re = 0;
  endtask

  task automatic peek_ctrl(output logic [31:0] d);
    host_addr = CTRL; #1 d = host_rdata;
  endtask

  task automatic load_slot(input int s, input logic [31:0] lenw, input int nbytes);
    logic [11:0] base = 12'(s * 256);
    hw(base, lenw);
    for (int w = 0; w < (nbytes + 3) / 4; w++)
      hw(base + 12'(8 + 4 * w), {pat(s, 4*w+3), pat(s, 4*w+2), pat(s, 4*w+1), pat(s, 4*w)});
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    int n = 0;
    do begin
      @(negedge clk); #2 peek_ctrl(c); n++;
    end while ((c[15:8] != 0 || tx_valid) && n < 5000);
    chk(n < 5000, "R8 completion reached", n, 0);
  endtask

  task automatic check_frame(input int k, input int s, input int len, input string req);
    logic [31:0] d;
    int errs = 0;
    chk(k < frm_cnt, req, frm_cnt, k + 1);
    if (k >= frm_cnt) return;
    chk(frm_len[k] == len, req, frm_len[k], len);
    chk(rx_b[frm_start[k]] == pat(s, 0), {req, " slot order"}, rx_b[frm_start[k]], pat(s, 0));
    for (int j = 0; j < frm_len[k]; j++) if (rx_b[frm_start[k] + j] != pat(s, j)) errs++;
    chk(errs == 0, {req, " bytes"}, errs, 0);
    hr(12'(s * 256 + 248), d);
    chk(d == frm_sec[k], "R7 ts seconds", d, frm_sec[k]);
    hr(12'(s * 256 + 252), d);
    chk(d == frm_ns[k], "R7 ts nanoseconds", d, frm_ns[k]);
  endtask

  task automatic t_reset();
    logic [31:0] c;
    @(negedge clk); peek_ctrl(c);
    chk(c == 0, "R1 ctrl after reset", c, 0);
    chk(!irq && !tx_valid, "R1 irq/valid after reset", {irq, tx_valid}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    hw(12'h354, 32'hA5C3_1E77);
    hw(12'h710, 32'h0BAD_F00D);
    hr(12'h354, d); chk(d == 32'hA5C3_1E77, "R2 slot3 word", d, 32'hA5C3_1E77);
    hr(12'h710, d); chk(d == 32'h0BAD_F00D, "R2 slot7 word", d, 32'h0BAD_F00D);
    hw(CTRL, 32'hFFFF_FF00);
    repeat (3) @(negedge clk);
    peek_ctrl(d);
    chk(d == 0, "R3 zero request bits ignored", d, 0);
    chk(!tx_valid, "R3 no send started", tx_valid, 0);
  endtask

  task automatic t_single();
    logic [31:0] c;
    int k0 = frm_cnt;
    rdy_mode = 1;
    load_slot(2, 10, 10);
    hw(CTRL, 32'h04);
    wait_idle();
    check_frame(k0, 2, 10, "R5 single frame");
    @(negedge clk); peek_ctrl(c);
    chk(c[7:0] == 0 && c[15:8] == 0 && c[18:16] == 2, "R8 ctrl after done", c, 32'h2_0000);
    chk(irq, "R9 irq raised", irq, 1);
    hr(CTRL, c);
    @(negedge clk);
    chk(!irq, "R9 irq cleared by read", irq, 0);
  endtask

  task automatic t_multi();
    logic [31:0] c;
    int k0 = frm_cnt;
    rdy_mode = 0;
    load_slot(5, 3, 3);
    load_slot(1, 4, 4);
    load_slot(6, 5, 5);
    hw(CTRL, 32'h62);
    repeat (4) @(negedge clk);
    peek_ctrl(c);
    chk(c[15:8] == 8'h62, "R3 waiting mask", c[15:8], 8'h62);
    rdy_mode = 1;
    wait_idle();
    check_frame(k0,     1, 4, "R4 first lowest");
    check_frame(k0 + 1, 5, 3, "R4 second");
    check_frame(k0 + 2, 6, 5, "R4 third");
    @(negedge clk); peek_ctrl(c);
    chk(c[18:16] == 6, "R8 last index", c[18:16], 6);
    hr(CTRL, c);
  endtask

  task automatic t_late_lower();
    logic [31:0] c;
    int k0 = frm_cnt;
    rdy_mode = 1;
    load_slot(4, 20, 20);
    load_slot(0, 6, 6);
    load_slot(7, 6, 6);
    hw(CTRL, 32'h10);
    while (!tx_valid) @(negedge clk);
    hw(CTRL, 32'h81);
    wait_idle();
    check_frame(k0,     4, 20, "R4 running frame");
    check_frame(k0 + 1, 0, 6,  "R4 late lower goes next");
    check_frame(k0 + 2, 7, 6,  "R4 higher last");
    hr(CTRL, c);
  endtask

  task automatic t_backpressure();
    logic [31:0] c;
    int k0 = frm_cnt;
    rdy_mode = 2;
    load_slot(3, 17, 17);
    hw(CTRL, 32'h08);
    wait_idle();
    check_frame(k0, 3, 17, "R6 toggled ready frame");
    hr(CTRL, c);
  endtask

  task automatic t_clamp();
    logic [31:0] c;
    int k0 = frm_cnt;
    rdy_mode = 1;
    load_slot(3, 0, 4);
    load_slot(5, 300, 240);
    hw(CTRL, 32'h28);
    wait_idle();
    check_frame(k0,     3, 1,   "R5 zero length clamp");
    check_frame(k0 + 1, 5, 240, "R5 long length clamp");
    hr(CTRL, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_single();
    t_multi();
    t_late_lower();
    t_backpressure();
    t_clamp();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule